// File: doc/BRIEF.md
# Isochronous Split Micro-frame Scheduler

A high-speed host reaches a full-speed isochronous endpoint through a hub. To do so it splits each full-speed transaction into start-splits and complete-splits, and places them in the eight micro-frames of a frame. This block is the decision stage of that scheduling. Each time the host visits a split-isochronous descriptor, it raises `eval_i` and presents the following:

- the descriptor's start mask and complete mask;
- its one-bit split state;
- the transfer direction;
- the maximum packet size;
- whether a back-pointer descriptor (the previous frame's descriptor) is available;
- the current micro-frame number, which is the low three bits of the frame index.

One clock later the block reports four things. It says whether to issue a split and of which kind. It selects either the current descriptor or the back-pointer descriptor. It gives the new split state to write back, and it raises a flag when the masks break a scheduling rule.

The two masks are interpreted under the split state bit. The encoding is 0 = "do start split" and 1 = "do complete split". Complete-mask bits at or below the lowest set start-mask position belong to the previous frame's transaction, which has wrapped into this frame. Those bits are serviced through the back-pointer descriptor, so all complete-splits of one IN payload keep a single buffer. When a back-pointer complete-split and a start-split fall in the same micro-frame, the block returns the complete-split on the first visit and the start-split on the next visit in that micro-frame.

Top module: `usplit_iso_sched`

## Requirements
- R1: A synchronous active-high `rst` drives `issue_o`, `kind_o`, `use_bp_o`, `state_o` and `err_o` to 0. State 0 means "do start split".
- R2: On an eval with `state_i`=0, the start-mask bit selected by `uframe_i` set, and no back-pointer complete due, the block issues a start-split one clock later. A start-split is `issue_o`=1, `kind_o`=0 and `use_bp_o`=0, and it comes with `state_o`=1.
- R3: On an eval with `state_i`=1 and the selected complete-mask bit set outside the wrap region, the block issues a complete-split (`kind_o`=1, `use_bp_o`=0). `state_o` is 0 when `eod_i` is set, or when no wrap bits exist and this micro-frame is the highest set complete-mask bit. Otherwise `state_o` is 1.
- R4: The wrap region is the set of complete-mask bits at positions at or below the lowest set start-mask bit; it is empty when the start mask is zero. When `bp_valid_i`=1 and the selected bit is in the wrap region, the block issues a complete-split with `use_bp_o`=1 whatever `state_i` is. `state_o` is 0 if this micro-frame is the highest wrap bit or `eod_i` is set, and 1 otherwise.
- R5: When `bp_valid_i`=0, wrap-region complete-mask bits cause no split of any kind.
- R6: An eval that issues nothing gives `issue_o`=0, `kind_o`=0, `use_bp_o`=0, and `state_o` equal to `state_i`.
- R7: After an eval that issued a back-pointer complete-split in micro-frame u, the next eval in the same micro-frame u is decided as if the back-pointer path were not there. This lets a start-split in that micro-frame follow the complete-split.
- R8: `err_o` pulses one clock after an eval in either of two cases. The first is an OUT transfer (`dir_in_i`=0) whose wrap region is non-empty. The second is an IN transfer whose start and complete masks share the lowest start position while `mps_i` is at most 579.
- R9: Without an eval, `issue_o` and `err_o` are 0 and `kind_o`, `use_bp_o` and `state_o` hold their values.
- R10: Start mask 0x01 with complete mask 0x3C, IN, gives a start-split in micro-frame 0 and complete-splits in micro-frames 2 to 5. The last of these returns the state to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| eval_i | input | 1 | Descriptor visit strobe |
| smask_i | input | 8 | Start mask, one bit per micro-frame |
| cmask_i | input | 8 | Complete mask, one bit per micro-frame |
| state_i | input | 1 | Current split state (0 start, 1 complete) |
| dir_in_i | input | 1 | 1 = IN transfer, 0 = OUT |
| mps_i | input | 11 | Maximum packet size in bytes |
| bp_valid_i | input | 1 | Back-pointer descriptor available |
| eod_i | input | 1 | Complete-split reports end of data |
| uframe_i | input | 3 | Current micro-frame number |
| issue_o | output | 1 | Issue a split this micro-frame |
| kind_o | output | 1 | 0 start-split, 1 complete-split |
| use_bp_o | output | 1 | Use the back-pointer descriptor |
| state_o | output | 1 | Updated split state bit |
| err_o | output | 1 | Scheduling rule violation |

## Verification
The assertions assume that `eval_i` is a single-cycle strobe. They also assume that all descriptor inputs are stable during the eval cycle, because the checks relate each output to the input values one cycle earlier. The stimulus drives every input on the falling edge and holds `eval_i` high for exactly one cycle, followed by an idle cycle. The sweep covers every micro-frame, both state values, both directions, both back-pointer settings, end-of-data on and off, and packet sizes on both sides of 579. Each visit is repeated so that the same-micro-frame ordering is exercised.

// File: rtl/usplit_pkg.sv
package usplit_pkg;
   typedef enum logic {
      SPLIT_START    = 1'b0,
      SPLIT_COMPLETE = 1'b1
   } split_kind_e;

   localparam logic ST_DO_START    = 1'b0;
   localparam logic ST_DO_COMPLETE = 1'b1;
endpackage

// File: rtl/usplit_mask_split.sv
module usplit_mask_split #(
   parameter int NUF = 8
) (
   input  logic [NUF-1:0] smask,
   input  logic [NUF-1:0] cmask,
   output logic [NUF-1:0] wrap_m,
   output logic [NUF-1:0] norm_m,
   output logic           shared_low
);
   logic [NUF-1:0] at_or_below;
   logic           has_start;

   // at_or_below[i] is set when no start bit sits below position i
   for (genvar i = 0; i < NUF; i++) begin : g_thermo
      if (i == 0) begin : g_first
         assign at_or_below[i] = 1'b1;
      end else begin : g_rest
         assign at_or_below[i] = ~|smask[i-1:0];
      end
   end

   assign has_start  = |smask;
   assign wrap_m     = has_start ? (cmask & at_or_below) : '0;
   assign norm_m     = cmask & ~wrap_m;
   assign shared_low = |(smask & cmask & at_or_below);
endmodule

// File: rtl/usplit_decide.sv
module usplit_decide
   import usplit_pkg::*;
#(
   parameter int NUF       = 8,
   parameter int UF_W      = 3,
   parameter int MPS_W     = 11,
   parameter int LARGE_MPS = 579
) (
   input  logic [NUF-1:0]   smask,
   input  logic [NUF-1:0]   cmask,
   input  logic [NUF-1:0]   wrap_m,
   input  logic [NUF-1:0]   norm_m,
   input  logic             shared_low,
   input  logic             state_in,
   input  logic             dir_in,
   input  logic [MPS_W-1:0] mps,
   input  logic             bp_valid,
   input  logic             eod,
   input  logic [UF_W-1:0]  uf,
   input  logic             served_same,
   output logic             issue,
   output split_kind_e      kind,
   output logic             use_bp,
   output logic             state_out,
   output logic             err,
   output logic             bp_hit
);
   logic [NUF-1:0] wrap_sh;
   logic [NUF-1:0] cmask_sh;
   logic           last_wrap;
   logic           last_cm;
   logic           small_pkt;

   assign wrap_sh   = wrap_m >> uf;
   assign cmask_sh  = cmask >> uf;
   assign last_wrap = (wrap_sh == NUF'(1));
   assign last_cm   = (cmask_sh == NUF'(1));
   assign small_pkt = (mps <= MPS_W'(LARGE_MPS));
   assign bp_hit    = wrap_m[uf] & bp_valid & ~served_same;

   always_comb begin
      issue     = 1'b0;
      kind      = SPLIT_START;
      use_bp    = 1'b0;
      state_out = state_in;
      if (bp_hit) begin
         issue     = 1'b1;
         kind      = SPLIT_COMPLETE;
         use_bp    = 1'b1;
         state_out = (last_wrap | eod) ? ST_DO_START : ST_DO_COMPLETE;
      end else if (state_in == ST_DO_START && smask[uf]) begin
         issue     = 1'b1;
         kind      = SPLIT_START;
         state_out = ST_DO_COMPLETE;
      end else if (state_in == ST_DO_COMPLETE && norm_m[uf]) begin
         issue     = 1'b1;
         kind      = SPLIT_COMPLETE;
         state_out = (((wrap_m == '0) & last_cm) | eod) ? ST_DO_START : ST_DO_COMPLETE;
      end
   end

   assign err = (~dir_in & (|wrap_m)) | (dir_in & shared_low & small_pkt);
endmodule

// File: rtl/usplit_iso_sched.sv
module usplit_iso_sched
   import usplit_pkg::*;
#(
   parameter int UF_W      = 3,
   parameter int MPS_W     = 11,
   parameter int LARGE_MPS = 579,
   localparam int NUF      = 1 << UF_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             eval_i,
   input  logic [NUF-1:0]   smask_i,
   input  logic [NUF-1:0]   cmask_i,
   input  logic             state_i,
   input  logic             dir_in_i,
   input  logic [MPS_W-1:0] mps_i,
   input  logic             bp_valid_i,
   input  logic             eod_i,
   input  logic [UF_W-1:0]  uframe_i,
   output logic             issue_o,
   output logic             kind_o,
   output logic             use_bp_o,
   output logic             state_o,
   output logic             err_o
);
   if (UF_W < 1 || UF_W > 4) begin : g_bad_uf
      $error("usplit_iso_sched: UF_W out of range");
   end
   if (LARGE_MPS >= (1 << MPS_W)) begin : g_bad_mps
      $error("usplit_iso_sched: LARGE_MPS does not fit MPS_W");
   end

   logic [NUF-1:0]  wrap_m;
   logic [NUF-1:0]  norm_m;
   logic            shared_low;
   logic            d_issue;
   split_kind_e     d_kind;
   logic            d_use_bp;
   logic            d_state;
   logic            d_err;
   logic            d_bp_hit;
   logic            served_q;
   logic [UF_W-1:0] served_uf_q;
   logic            served_same;

   assign served_same = served_q & (served_uf_q == uframe_i);

   usplit_mask_split #(.NUF(NUF)) u_split (
      .smask      (smask_i),
      .cmask      (cmask_i),
      .wrap_m     (wrap_m),
      .norm_m     (norm_m),
      .shared_low (shared_low)
   );

   usplit_decide #(
      .NUF(NUF), .UF_W(UF_W), .MPS_W(MPS_W), .LARGE_MPS(LARGE_MPS)
   ) u_decide (
      .smask       (smask_i),
      .cmask       (cmask_i),
      .wrap_m      (wrap_m),
      .norm_m      (norm_m),
      .shared_low  (shared_low),
      .state_in    (state_i),
      .dir_in      (dir_in_i),
      .mps         (mps_i),
      .bp_valid    (bp_valid_i),
      .eod         (eod_i),
      .uf          (uframe_i),
      .served_same (served_same),
      .issue       (d_issue),
      .kind        (d_kind),
      .use_bp      (d_use_bp),
      .state_out   (d_state),
      .err         (d_err),
      .bp_hit      (d_bp_hit)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         issue_o     <= 1'b0;
         kind_o      <= 1'b0;
         use_bp_o    <= 1'b0;
         state_o     <= ST_DO_START;
         err_o       <= 1'b0;
         served_q    <= 1'b0;
         served_uf_q <= '0;
      end else if (eval_i) begin
         issue_o     <= d_issue;
         kind_o      <= d_kind;
         use_bp_o    <= d_use_bp;
         state_o     <= d_state;
         err_o       <= d_err;
         served_q    <= d_bp_hit;
         served_uf_q <= uframe_i;
      end else begin
         issue_o <= 1'b0;
         err_o   <= 1'b0;
      end
   end
endmodule

// File: rtl/usplit_iso_sched_chk.sv
module usplit_iso_sched_chk #(
   parameter int UF_W  = 3,
   parameter int MPS_W = 11,
   localparam int NUF  = 1 << UF_W
) (
   input logic             clk,
   input logic             rst,
   input logic             eval_i,
   input logic [NUF-1:0]   smask_i,
   input logic [NUF-1:0]   cmask_i,
   input logic             state_i,
   input logic             bp_valid_i,
   input logic [UF_W-1:0]  uframe_i,
   input logic             issue_o,
   input logic             kind_o,
   input logic             use_bp_o,
   input logic             state_o,
   input logic             err_o
);
   logic sel_s;
   logic sel_c;
   always_comb begin
      sel_s = smask_i[uframe_i];
      sel_c = cmask_i[uframe_i];
   end

   p_issue_after_eval_r9: assert property (@(posedge clk) disable iff (rst)
      issue_o |-> $past(eval_i));

   p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
      (!$past(eval_i) && !$past(rst)) |-> (!issue_o && !err_o && $stable(state_o)));

   p_start_gate_r2: assert property (@(posedge clk) disable iff (rst)
      (issue_o && !kind_o) |-> ($past(sel_s) && !$past(state_i) && state_o && !use_bp_o));

   p_complete_gate_r3: assert property (@(posedge clk) disable iff (rst)
      (issue_o && kind_o && !use_bp_o) |-> ($past(sel_c) && $past(state_i)));

   p_bp_needs_valid_r4: assert property (@(posedge clk) disable iff (rst)
      (issue_o && use_bp_o) |-> (kind_o && $past(bp_valid_i) && $past(sel_c)));

   p_none_keeps_state_r6: assert property (@(posedge clk) disable iff (rst)
      ($past(eval_i) && !$past(rst) && !issue_o) |-> (state_o == $past(state_i) && !use_bp_o));
endmodule

bind usplit_iso_sched usplit_iso_sched_chk #(.UF_W(UF_W), .MPS_W(MPS_W)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .eval_i     (eval_i),
   .smask_i    (smask_i),
   .cmask_i    (cmask_i),
   .state_i    (state_i),
   .bp_valid_i (bp_valid_i),
   .uframe_i   (uframe_i),
   .issue_o    (issue_o),
   .kind_o     (kind_o),
   .use_bp_o   (use_bp_o),
   .state_o    (state_o),
   .err_o      (err_o)
);

// File: tb/usplit_iso_sched_tb.sv
module usplit_iso_sched_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        eval_i = 1'b0;
   logic [7:0]  smask_i = '0;
   logic [7:0]  cmask_i = '0;
   logic        state_i = 1'b0;
   logic        dir_in_i = 1'b0;
   logic [10:0] mps_i = '0;
   logic        bp_valid_i = 1'b0;
   logic        eod_i = 1'b0;
   logic [2:0]  uframe_i = '0;
   logic        issue_o, kind_o, use_bp_o, state_o, err_o;

   int checks = 0;
   int errors = 0;
   logic       m_served = 1'b0;
   logic [2:0] m_uf = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   usplit_iso_sched u_dut (
      .clk(clk), .rst(rst), .eval_i(eval_i), .smask_i(smask_i), .cmask_i(cmask_i),
      .state_i(state_i), .dir_in_i(dir_in_i), .mps_i(mps_i), .bp_valid_i(bp_valid_i),
      .eod_i(eod_i), .uframe_i(uframe_i), .issue_o(issue_o), .kind_o(kind_o),
      .use_bp_o(use_bp_o), .state_o(state_o), .err_o(err_o)
   );

   task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: {issue,kind,bp,state,err} actual %b expected %b", req, act, exp);
      end
   endtask

   // Reference built from the requirement text
   task automatic model(input logic [7:0] sm, input logic [7:0] cm, input logic st,
                        input logic dir, input logic bpv, input logic eod,
                        input logic [2:0] u, input logic [10:0] mps,
                        output logic [4:0] exp, output logic hit, output string tag);
      int lo = 8;
      int hi_w = -1;
      int hi_c = -1;
      logic [7:0] wrap = '0;
      logic [7:0] norm;
      logic e;
      logic served_here;
      for (int i = 7; i >= 0; i--) if (sm[i]) lo = i;
      for (int i = 0; i < 8; i++) if (lo < 8 && i <= lo) wrap[i] = cm[i];
      norm = cm & ~wrap;
      for (int i = 0; i < 8; i++) begin
         if (wrap[i]) hi_w = i;
         if (cm[i]) hi_c = i;
      end
      e = (!dir && wrap != 0) || (dir && lo < 8 && sm[lo] && cm[lo] && mps <= 11'd579);
      served_here = m_served && (m_uf == u);
      hit = wrap[u] && bpv && !served_here;
      if (hit) begin
         exp = {1'b1, 1'b1, 1'b1, ((int'(u) == hi_w) || eod) ? 1'b0 : 1'b1, e};
         tag = "R4";
      end else if (!st && sm[u]) begin
         exp = {1'b1, 1'b0, 1'b0, 1'b1, e};
         tag = "R2";
      end else if (st && norm[u]) begin
         exp = {1'b1, 1'b1, 1'b0, ((wrap == 0 && int'(u) == hi_c) || eod) ? 1'b0 : 1'b1, e};
         tag = "R3";
      end else begin
         exp = {1'b0, 1'b0, 1'b0, st, e};
         tag = (wrap[u] && !bpv) ? "R5" : "R6";
      end
   endtask

   task automatic do_eval(input logic [7:0] sm, input logic [7:0] cm, input logic st,
                          input logic dir, input logic bpv, input logic eod,
                          input logic [2:0] u, input logic [10:0] mps,
                          output logic [4:0] got);
      @(negedge clk);
      smask_i = sm; cmask_i = cm; state_i = st; dir_in_i = dir;
      bp_valid_i = bpv; eod_i = eod; uframe_i = u; mps_i = mps; eval_i = 1'b1;
      @(negedge clk);
      eval_i = 1'b0;
      got = {issue_o, kind_o, use_bp_o, state_o, err_o};
   endtask

   task automatic sweep_eval(input logic [7:0] sm, input logic [7:0] cm, input logic st,
                             input logic dir, input logic bpv, input logic eod,
                             input logic [2:0] u, input logic [10:0] mps);
      logic [4:0] exp, got;
      logic hit;
      string tag;
      model(sm, cm, st, dir, bpv, eod, u, mps, exp, hit, tag);
      do_eval(sm, cm, st, dir, bpv, eod, u, mps, got);
      m_served = hit;
      m_uf = u;
      check(tag, {got[4:1], 1'b0}, {exp[4:1], 1'b0});
      check("R8", {4'b0, got[0]}, {4'b0, exp[0]});
      @(negedge clk);
      check("R9", {issue_o, kind_o, use_bp_o, state_o, err_o}, {1'b0, got[3:1], 1'b0});
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] sms [6];
      logic [7:0] cms [6];
      logic [4:0] got;
      sms[0] = 8'h01; cms[0] = 8'h3C;
      sms[1] = 8'h40; cms[1] = 8'h83;
      sms[2] = 8'h10; cms[2] = 8'h30;
      sms[3] = 8'h00; cms[3] = 8'h0F;
      sms[4] = 8'h04; cms[4] = 8'h00;
      sms[5] = 8'h21; cms[5] = 8'hC7;

      repeat (3) @(negedge clk);
      // R1: reset values
      check("R1", {issue_o, kind_o, use_bp_o, state_o, err_o}, 5'b00000);
      rst = 1'b0;

      // R10: the example masks walked through one frame
      do_eval(8'h01, 8'h3C, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 11'd188, got);
      check("R10", got, 5'b10010);
      for (int u = 2; u <= 5; u++) begin
         do_eval(8'h01, 8'h3C, 1'b1, 1'b1, 1'b0, 1'b0, 3'(u), 11'd188, got);
         check("R10", got, (u == 5) ? 5'b11000 : 5'b11010);
      end

      // R7: back-pointer complete then start in the same micro-frame
      do_eval(8'h10, 8'h30, 1'b0, 1'b1, 1'b1, 1'b0, 3'd4, 11'd600, got);
      check("R7", got, 5'b11100);
      do_eval(8'h10, 8'h30, 1'b0, 1'b1, 1'b1, 1'b0, 3'd4, 11'd600, got);
      check("R7", got, 5'b10010);
      do_eval(8'h10, 8'h30, 1'b0, 1'b1, 1'b1, 1'b0, 3'd4, 11'd600, got);
      check("R7", got, 5'b11100);

      // sweep from a fresh reset so the ordering flag starts clear
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check("R1", {issue_o, kind_o, use_bp_o, state_o, err_o}, 5'b00000);
      m_served = 1'b0;
      m_uf = '0;

      for (int p = 0; p < 6; p++)
         for (int st = 0; st < 2; st++)
            for (int dir = 0; dir < 2; dir++)
               for (int bpv = 0; bpv < 2; bpv++)
                  for (int eod = 0; eod < 2; eod++)
                     for (int sz = 0; sz < 2; sz++)
                        for (int u = 0; u < 8; u++)
                           for (int rep = 0; rep < 2; rep++)
                              sweep_eval(sms[p], cms[p], 1'(st), 1'(dir), 1'(bpv),
                                         1'(eod), 3'(u), sz ? 11'd580 : 11'd579);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule